// File: doc/BRIEF.md
# Time-Multiplexed Address Calculation Unit

This unit produces the three memory addresses needed by one iteration of the loop body `B[i] = f(A[2*i+1], B[i-1])`. Each address is a direct function of the loop iterator. A single shift-and-add datapath evaluates all three in turn, and it uses no multiplier. The factor two on the iterator comes from a left shift by one. The offsets of +1 and -1 are folded into the adder as a selectable constant.

A start strobe accepted while the unit is idle captures the iterator and both base addresses. On the next three cycles the unit emits, in this order, the read address of A, the write address of B[i] and the read address of B[i-1]. Each address carries a tag that names the equation and a one-cycle valid flag. The caller supplies the iterator, either as an absolute value or from its own loop counter. Loop sequencing, the memories and the `f()` datapath belong to the surrounding design.

Top module: `acu_tm`

## Requirements
- R1: While reset is applied and on the first idle cycles after it, `vld_o`, `oor_o`, `tag_o` and `addr_o` are all zero.
- R2: A start strobe sampled while idle produces valid outputs on the three following clock edges, with tags 0 (A read), then 1 (B write), then 2 (B read).
- R3: The tag-0 address equals `base_a + 2*iter + 1`, modulo 2^16.
- R4: The tag-1 address equals `base_b + iter`, modulo 2^16.
- R5: The tag-2 address equals `base_b + iter - 1`, modulo 2^16. For iter = 0 this is `base_b - 1`.
- R6: `oor_o` is high only with the tag-2 output for iter = 0, and low on every other cycle.
- R7: `vld_o` is high for exactly one cycle per emitted address and low on all other cycles.
- R8: A start strobe sampled while a sequence is in progress is ignored. No extra outputs appear and the running sequence is unchanged.
- R9: The iterator and both bases are sampled only when a start is accepted. Changes to them during a sequence do not alter its addresses.
- R10: Additions wrap modulo 2^16. For example, base_a = 0xFFFF with iter = 511 gives 0x03FE, and base_b = 0 with iter = 0 gives 0xFFFF for the tag-2 output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Start strobe for one address triple |
| iter_i | input | ITER_W (9) | Loop iterator value |
| base_a_i | input | ADDR_W (16) | Base address of array A |
| base_b_i | input | ADDR_W (16) | Base address of array B |
| addr_o | output | ADDR_W (16) | Computed address |
| tag_o | output | 2 | Equation tag: 0 A read, 1 B write, 2 B read |
| vld_o | output | 1 | Address valid, one cycle per address |
| oor_o | output | 1 | B[i-1] index is below zero (iter = 0) |

## Verification
The assertions check on every cycle that tags follow the fixed order 0, 1, 2 and that valid drops after the third output. They also check that a start seen mid-sequence never restarts the sequencer, that the out-of-range flag appears only with a tag-2 output, and that the tag-2 address is one below the tag-1 address emitted just before it. Only the bench scenarios can show that the absolute address values are correct for chosen bases and iterators. The same holds for wrap-around at the ends of the iterator and address ranges, and for the operands being captured at start and not tracked afterwards.

// File: rtl/acu_pkg.sv
package acu_pkg;

  // Sequencer phase; one phase per emitted equation
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_A    = 2'd1,
    PH_BW   = 2'd2,
    PH_BR   = 2'd3
  } phase_t;

  // Constant folded into the adder
  typedef enum logic [1:0] {
    OFS_ZERO = 2'd0,
    OFS_INC  = 2'd1,
    OFS_DEC  = 2'd2
  } ofs_t;

  localparam logic [1:0] TAG_A  = 2'd0;
  localparam logic [1:0] TAG_BW = 2'd1;
  localparam logic [1:0] TAG_BR = 2'd2;

  // Datapath control word for one cycle
  typedef struct packed {
    logic       active;
    logic       sel_b;
    logic       shift1;
    ofs_t       ofs;
    logic [1:0] tag;
  } ctl_t;

endpackage

// File: rtl/acu_seq.sv
module acu_seq
  import acu_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic load,
  output ctl_t ctl
);

  phase_t state_q;
  phase_t state_n;

  assign load = start && (state_q == PH_IDLE);

  // next-state process
  always_comb begin
    state_n = state_q;
    unique case (state_q)
      PH_IDLE: if (load) state_n = PH_A;
      PH_A:    state_n = PH_BW;
      PH_BW:   state_n = PH_BR;
      PH_BR:   state_n = PH_IDLE;
      default: state_n = PH_IDLE;
    endcase
  end

  // state register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= PH_IDLE;
    else        state_q <= state_n;
  end

  // decode of the current phase into the shared datapath controls
  always_comb begin
    ctl = '{active: 1'b0, sel_b: 1'b0, shift1: 1'b0, ofs: OFS_ZERO, tag: TAG_A};
    unique case (state_q)
      PH_A:    ctl = '{active: 1'b1, sel_b: 1'b0, shift1: 1'b1, ofs: OFS_INC,  tag: TAG_A};
      PH_BW:   ctl = '{active: 1'b1, sel_b: 1'b1, shift1: 1'b0, ofs: OFS_ZERO, tag: TAG_BW};
      PH_BR:   ctl = '{active: 1'b1, sel_b: 1'b1, shift1: 1'b0, ofs: OFS_DEC,  tag: TAG_BR};
      default: ;
    endcase
  end

  // R8
  busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != PH_IDLE) |=> (state_q != PH_A))
    else $error("start accepted while busy");

  // R2
  phase_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PH_A) |=> (state_q == PH_BW))
    else $error("phase order broken");

endmodule

// File: rtl/acu_shift.sv
module acu_shift #(
  parameter int IN_W  = 9,
  parameter int OUT_W = 16,
  parameter int SH_W  = 1
) (
  input  logic [IN_W-1:0]  din,
  input  logic [SH_W-1:0]  sh,
  output logic [OUT_W-1:0] dout
);

  localparam int N_SH = 1 << SH_W;

  logic [OUT_W-1:0] cand [N_SH];

  // one candidate per shift mode, picked by the mode input
  for (genvar k = 0; k < N_SH; k++) begin : g_mode
    assign cand[k] = OUT_W'(din) << k;
  end

  assign dout = cand[sh];

endmodule

// File: rtl/acu_addsub.sv
module acu_addsub
  import acu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  ofs_t         ofs,
  output logic [W-1:0] sum
);

  logic [W-1:0] k;

  // offset as a third operand: +1, 0 or all ones (-1)
  always_comb begin
    unique case (ofs)
      OFS_INC: k = W'(1);
      OFS_DEC: k = '1;
      default: k = '0;
    endcase
  end

  assign sum = a + b + k;

endmodule

// File: rtl/acu_tm.sv
module acu_tm
  import acu_pkg::*;
#(
  parameter int ITER_W = 9,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ITER_W-1:0] iter_i,
  input  logic [ADDR_W-1:0] base_a_i,
  input  logic [ADDR_W-1:0] base_b_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [1:0]        tag_o,
  output logic              vld_o,
  output logic              oor_o
);

  localparam int SH_W = 1;

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic load;
  ctl_t ctl;

  acu_seq u_seq (
    .clk   (clk),
    .rst_n (rst_sync_q),
    .start (start_i),
    .load  (load),
    .ctl   (ctl)
  );

  // operand capture, enabled by an accepted start only
  logic [ITER_W-1:0] iter_q, iter_n;
  logic [ADDR_W-1:0] ba_q, ba_n, bb_q, bb_n;

  always_comb begin
    iter_n = iter_q;
    ba_n   = ba_q;
    bb_n   = bb_q;
    if (load) begin
      iter_n = iter_i;
      ba_n   = base_a_i;
      bb_n   = base_b_i;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      iter_q <= '0;
      ba_q   <= '0;
      bb_q   <= '0;
    end else begin
      iter_q <= iter_n;
      ba_q   <= ba_n;
      bb_q   <= bb_n;
    end
  end

  // shared datapath: base mux, mode-switched shifter, offset adder
  logic [ADDR_W-1:0] base_sel, idx_term, sum;

  assign base_sel = ctl.sel_b ? bb_q : ba_q;

  acu_shift #(.IN_W(ITER_W), .OUT_W(ADDR_W), .SH_W(SH_W)) u_shift (
    .din  (iter_q),
    .sh   (SH_W'(ctl.shift1)),
    .dout (idx_term)
  );

  acu_addsub #(.W(ADDR_W)) u_add (
    .a   (base_sel),
    .b   (idx_term),
    .ofs (ctl.ofs),
    .sum (sum)
  );

  // output registers
  logic [ADDR_W-1:0] addr_q, addr_n;
  logic [1:0]        tag_q, tag_n;
  logic              vld_q, vld_n, oor_q, oor_n;

  always_comb begin
    addr_n = addr_q;
    tag_n  = tag_q;
    vld_n  = ctl.active;
    oor_n  = ctl.active && (ctl.tag == TAG_BR) && (iter_q == '0);
    if (ctl.active) begin
      addr_n = sum;
      tag_n  = ctl.tag;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      addr_q <= '0;
      tag_q  <= TAG_A;
      vld_q  <= 1'b0;
      oor_q  <= 1'b0;
    end else begin
      addr_q <= addr_n;
      tag_q  <= tag_n;
      vld_q  <= vld_n;
      oor_q  <= oor_n;
    end
  end

  assign addr_o = addr_q;
  assign tag_o  = tag_q;
  assign vld_o  = vld_q;
  assign oor_o  = oor_q;

  // R2
  tag_a_then_bw_chk: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (vld_o && tag_o == TAG_A) |=> (vld_o && tag_o == TAG_BW))
    else $error("B write did not follow A");

  // R2
  tag_bw_then_br_chk: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (vld_o && tag_o == TAG_BW) |=> (vld_o && tag_o == TAG_BR))
    else $error("B read did not follow B write");

  // R7
  vld_ends_after_br_chk: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (vld_o && tag_o == TAG_BR) |=> !vld_o)
    else $error("valid held past the third address");

  // R6
  oor_only_br_chk: assert property (@(posedge clk) disable iff (!rst_sync_q)
    oor_o |-> (vld_o && tag_o == TAG_BR))
    else $error("out-of-range flag on wrong output");

  // R5
  br_below_bw_chk: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (vld_o && tag_o == TAG_BR) |-> (addr_o == $past(addr_o) - ADDR_W'(1)))
    else $error("B read address not one below B write");

endmodule

// File: tb/acu_tm_bench.sv
`timescale 1ns/1ps
module acu_tm_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i;
  logic [8:0]  iter_i;
  logic [15:0] base_a_i, base_b_i;
  logic [15:0] addr_o;
  logic [1:0]  tag_o;
  logic        vld_o, oor_o;

  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  acu_tm u_acu_tm (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .iter_i(iter_i),
    .base_a_i(base_a_i), .base_b_i(base_b_i),
    .addr_o(addr_o), .tag_o(tag_o), .vld_o(vld_o), .oor_o(oor_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; start_i = 1'b0; iter_i = '0; base_a_i = '0; base_b_i = '0;
    repeat (3) @(negedge clk);
    chk("R1 vld in reset", 32'(vld_o), 0);
    chk("R1 oor in reset", 32'(oor_o), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 vld after reset", 32'(vld_o), 0);
    chk("R1 tag after reset", 32'(tag_o), 0);
    chk("R1 addr after reset", 32'(addr_o), 0);
  endtask

  // One address triple; optional busy-start strobe (R8) and input changes (R9)
  task automatic t_triple(input logic [8:0] i, input logic [15:0] ba, input logic [15:0] bb,
                          input bit poke_start, input bit poke_ops);
    logic [15:0] ea, ebw, ebr;
    ea  = 16'(32'(ba) + 2 * 32'(i) + 1);
    ebw = 16'(32'(bb) + 32'(i));
    ebr = 16'(32'(bb) + 32'(i) - 1);
    start_i = 1'b1; iter_i = i; base_a_i = ba; base_b_i = bb;
    @(negedge clk);
    start_i = 1'b0;
    chk("R7 no valid before first address", 32'(vld_o), 0);
    if (poke_start) begin start_i = 1'b1; iter_i = i ^ 9'h0AA; end
    if (poke_ops) begin iter_i = ~i; base_a_i = ~ba; base_b_i = ~bb; end
    @(negedge clk);
    chk("R2 A valid", 32'(vld_o), 1);
    chk("R2 A tag", 32'(tag_o), 0);
    chk("R3 R9 R10 A address", 32'(addr_o), 32'(ea));
    chk("R6 A oor", 32'(oor_o), 0);
    @(negedge clk);
    chk("R2 BW valid", 32'(vld_o), 1);
    chk("R2 BW tag", 32'(tag_o), 1);
    chk("R4 R9 BW address", 32'(addr_o), 32'(ebw));
    chk("R6 BW oor", 32'(oor_o), 0);
    @(negedge clk);
    start_i = 1'b0;
    chk("R2 BR valid", 32'(vld_o), 1);
    chk("R2 BR tag", 32'(tag_o), 2);
    chk("R5 R9 R10 BR address", 32'(addr_o), 32'(ebr));
    chk("R5 R6 BR oor", 32'(oor_o), 32'(i == 9'd0));
    @(negedge clk);
    chk("R7 R8 valid low after triple", 32'(vld_o), 0);
    chk("R6 oor low after triple", 32'(oor_o), 0);
    @(negedge clk);
    chk("R8 no sequence from busy start", 32'(vld_o), 0);
  endtask

  initial begin
    #1_000_000;
    bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_triple(9'd5,   16'h1000, 16'h2000, 1'b0, 1'b0); // R3 R4 R5 typical
    t_triple(9'd0,   16'h0100, 16'h0800, 1'b0, 1'b0); // R5 R6 iter zero
    t_triple(9'd511, 16'hFFFF, 16'h7F00, 1'b0, 1'b0); // R10 wrap on A
    t_triple(9'd0,   16'h0000, 16'h0000, 1'b0, 1'b0); // R10 wrap on B read
    t_triple(9'd37,  16'h0040, 16'h0300, 1'b1, 1'b0); // R8 start while busy
    t_triple(9'd200, 16'h4321, 16'h1234, 1'b0, 1'b1); // R9 inputs change
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule